// File: doc/BRIEF.md
# Burst QPSK Symbol Generator

This block turns a serial bit stream, framed by a transmit-enable input, into QPSK symbol pairs for a burst transmitter. A single master clock drives all of its logic. The block divides this clock down to make a bit clock for the data source. On each rising edge of that bit clock it samples the enable and the data bit. Bits taken while the enable is high are grouped into pairs, with the first bit of every burst used as the in-phase bit. Each completed pair is presented as one signed value per rail, together with a one-cycle strobe.

A burst-active flag rises with the burst and stays high after the enable drops. It falls only after enough bit periods have passed for the last symbol to clear a downstream shaping filter. A transmitter can therefore gate its output with this flag and turn off cleanly. If a burst ends after an odd number of bits, the open pair is completed with a zero quadrature bit and a sticky error flag is set.

The symbol output has no back-pressure. Symbols leave at a fixed rate set by the bit clock, and a consumer must accept each strobe in the cycle it appears. The active-low reset takes effect at once. Internal logic resumes on the second master-clock edge after reset is released.

Top module: `bqpsk_symbol_gen`

## Requirements
- R1: `bit_clk` has a period of CLK_DIV master clocks. It is high for the first CLK_DIV/2 of them. `tx_en` and `tx_bit` are sampled on the master-clock edge at which `bit_clk` rises.
- R2: The first bit sampled with `tx_en` high after any idle or reset is the I bit. Later bits alternate Q, I, Q and so on.
- R3: Each rail maps bit 0 to +1 (2'b01) and bit 1 to -1 (2'b11). The rails are two-bit two's-complement values.
- R4: `sym_stb` is high for exactly one master clock. It rises on the same edge as the `bit_clk` rise that sampled the pair's Q bit. `sym_i` and `sym_q` are valid while it is high, and no strobe occurs between bit-clock rises.
- R5: If `tx_en` is sampled low while an I bit is waiting, a symbol is emitted with Q taken as bit 0 (+1). At the same time `odd_err` is set, and it stays set until reset.
- R6: `burst_active` rises at the first bit-clock sample with `tx_en` high. It falls at the 2*FLUSH_SYMS-th consecutive sample with `tx_en` low.
- R7: A high `tx_en` sample during the drain keeps `burst_active` high and restarts the drain count.
- R8: `tx_bit` is ignored while `tx_en` is sampled low. No strobe is produced, and the pairing state is not touched.
- R9: While `rst_n` is low, `bit_clk`, `sym_stb`, `sym_i`, `sym_q`, `burst_active` and `odd_err` are 0 without waiting for a clock. After `rst_n` rises, `bit_clk` first rises on the third master-clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, asynchronous assertion |
| tx_en | input | 1 | Burst enable from data source |
| tx_bit | input | 1 | Serial data bit |
| bit_clk | output | 1 | Generated bit clock for the data source |
| sym_i | output | 2 | In-phase symbol value, signed |
| sym_q | output | 2 | Quadrature symbol value, signed |
| sym_stb | output | 1 | One-cycle symbol strobe |
| burst_active | output | 1 | Extended transmit enable |
| odd_err | output | 1 | Sticky odd-length burst flag |

## Verification
The hardest case to reach from the ports is a burst that starts again while the previous one is still draining. In that case the drain count must restart and the I/Q phase must begin fresh. The stimulus reaches it by scheduling a second burst only a few bit periods after the first one ends, well inside the drain window. A second hard case is an odd burst followed by an asynchronous reset in the middle of a later burst. The stimulus covers it by asserting reset between clock edges and checking every output within one nanosecond.

// File: rtl/bqpsk_pkg.sv
package bqpsk_pkg;

  typedef logic signed [1:0] rail_t;

  localparam rail_t RAIL_POS = 2'sb01;
  localparam rail_t RAIL_NEG = 2'sb11;
  localparam rail_t RAIL_OFF = 2'sb00;

  typedef struct packed {
    rail_t i;
    rail_t q;
  } sym_t;

  // bit 0 -> +1, bit 1 -> -1 on either rail
  function automatic rail_t map_bit(input logic b);
    return b ? RAIL_NEG : RAIL_POS;
  endfunction

endpackage

// File: rtl/bqpsk_rst_sync.sv
module bqpsk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_int_n
);
  logic [STAGES-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-2:0], 1'b1};
  end

  assign rst_int_n = shreg[STAGES-1];
endmodule

// File: rtl/bqpsk_bit_clk.sv
module bqpsk_bit_clk #(
  parameter int DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic bit_clk
);
  localparam int CW   = $clog2(DIV);
  localparam int HALF = DIV / 2;
  localparam logic [CW-1:0] LAST  = CW'(DIV - 1);
  localparam logic [CW-1:0] FALLC = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  assign tick = (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= LAST;
      bit_clk <= 1'b0;
    end else begin
      cnt <= tick ? '0 : cnt + CW'(1);
      if (tick)               bit_clk <= 1'b1;
      else if (cnt == FALLC)  bit_clk <= 1'b0;
    end
  end

  assert_rise_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> $rose(bit_clk));
  assert_rise_only_on_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !$rose(bit_clk));
endmodule

// File: rtl/bqpsk_pairer.sv
module bqpsk_pairer
  import bqpsk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  logic  en,
  input  logic  din,
  output rail_t sym_i,
  output rail_t sym_q,
  output logic  stb,
  output logic  odd_err
);
  logic have_i;
  logic hold_i;
  sym_t sym_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_i  <= 1'b0;
      hold_i  <= 1'b0;
      sym_r   <= '{i: RAIL_OFF, q: RAIL_OFF};
      stb     <= 1'b0;
      odd_err <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (tick) begin
        if (en) begin
          if (!have_i) begin
            hold_i <= din;
            have_i <= 1'b1;
          end else begin
            sym_r  <= '{i: map_bit(hold_i), q: map_bit(din)};
            stb    <= 1'b1;
            have_i <= 1'b0;
          end
        end else if (have_i) begin
          sym_r   <= '{i: map_bit(hold_i), q: RAIL_POS};
          stb     <= 1'b1;
          have_i  <= 1'b0;
          odd_err <= 1'b1;
        end
      end
    end
  end

  assign sym_i = sym_r.i;
  assign sym_q = sym_r.q;

  assert_stb_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stb |=> !stb);
  assert_stb_after_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !stb);
  assert_pad_q_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en && have_i) |=> (stb && sym_q == RAIL_POS && odd_err));
  assert_odd_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    odd_err |=> odd_err);
  assert_idle_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !en && !have_i) |=> (!stb && $stable(sym_i) && $stable(sym_q)));
endmodule

// File: rtl/bqpsk_drain.sv
module bqpsk_drain #(
  parameter int DRAIN_TICKS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic en,
  output logic active
);
  localparam int LW = $clog2(DRAIN_TICKS + 1);
  localparam logic [LW-1:0] LAST = LW'(DRAIN_TICKS - 1);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active  <= 1'b0;
      low_cnt <= '0;
    end else if (tick) begin
      if (en) begin
        active  <= 1'b1;
        low_cnt <= '0;
      end else if (active) begin
        if (low_cnt == LAST) begin
          active  <= 1'b0;
          low_cnt <= '0;
        end else begin
          low_cnt <= low_cnt + LW'(1);
        end
      end
    end
  end

  assert_active_on_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && en) |=> active);
  assert_hold_in_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !(tick && !en && low_cnt == LAST)) |=> active);
  assert_idle_stays_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(tick && en)) |=> !active);
endmodule

// File: rtl/bqpsk_symbol_gen.sv
module bqpsk_symbol_gen
  import bqpsk_pkg::*;
#(
  parameter int CLK_DIV    = 100,
  parameter int FLUSH_SYMS = 8,
  parameter int RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              tx_bit,
  output logic              bit_clk,
  output logic signed [1:0] sym_i,
  output logic signed [1:0] sym_q,
  output logic              sym_stb,
  output logic              burst_active,
  output logic              odd_err
);
  localparam int DRAIN_TICKS = 2 * FLUSH_SYMS;

  logic rst_int_n;
  logic tick;

  bqpsk_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_int_n(rst_int_n));

  bqpsk_bit_clk #(.DIV(CLK_DIV)) u_bclk (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .bit_clk(bit_clk));

  bqpsk_pairer u_pair (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .en(tx_en), .din(tx_bit),
    .sym_i(sym_i), .sym_q(sym_q), .stb(sym_stb), .odd_err(odd_err));

  bqpsk_drain #(.DRAIN_TICKS(DRAIN_TICKS)) u_drain (
    .clk(clk), .rst_n(rst_int_n), .tick(tick), .en(tx_en),
    .active(burst_active));

  assert_stb_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    sym_stb |-> burst_active);
  assert_rails_legal_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    sym_stb |-> ((sym_i == RAIL_POS || sym_i == RAIL_NEG) &&
                 (sym_q == RAIL_POS || sym_q == RAIL_NEG)));
endmodule

// File: tb/bqpsk_symbol_gen_tb.sv
module bqpsk_symbol_gen_tb_top;
  localparam int DIV   = 100;
  localparam int FLUSH = 8;
  localparam int DRAIN = 2 * FLUSH;

  logic clk = 1'b0, rst_n = 1'b1, tx_en = 1'b0, tx_bit = 1'b0;
  logic bit_clk, sym_stb, burst_active, odd_err;
  logic signed [1:0] sym_i, sym_q;

  bqpsk_symbol_gen #(.CLK_DIV(DIV), .FLUSH_SYMS(FLUSH)) dut_i (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_bit(tx_bit),
    .bit_clk(bit_clk), .sym_i(sym_i), .sym_q(sym_q), .sym_stb(sym_stb),
    .burst_active(burst_active), .odd_err(odd_err));

  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  bit aligned = 1'b0;
  bit m_have, m_hold, m_active, m_odd;
  int m_low, ph;
  logic [1:0] stim_q[$];

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int rail(input bit b);
    return b ? -1 : 1;
  endfunction

  task automatic model_clear();
    m_have = 0; m_hold = 0; m_active = 0; m_odd = 0; m_low = 0;
  endtask

  task automatic model_tick();
    bit stb = 0;
    int ei = 0, eq = 0;
    if (tx_en) begin
      m_active = 1; m_low = 0;
      if (!m_have) begin m_hold = tx_bit; m_have = 1; end
      else begin stb = 1; ei = rail(m_hold); eq = rail(tx_bit); m_have = 0; end
    end else begin
      if (m_have) begin stb = 1; ei = rail(m_hold); eq = 1; m_have = 0; m_odd = 1; end
      if (m_active) begin
        m_low++;
        if (m_low == DRAIN) begin m_active = 0; m_low = 0; end
      end
    end
    check(sym_stb == stb, tx_en ? "R2 R4 strobe on pair" : "R8 R5 strobe with enable low",
          sym_stb, stb);
    if (stb) begin
      check($signed(sym_i) == ei, "R3 R2 I rail", $signed(sym_i), ei);
      check($signed(sym_q) == eq, "R3 R5 Q rail", $signed(sym_q), eq);
    end
    if (stim_q.size() > 0) begin
      logic [1:0] v = stim_q.pop_front();
      tx_en = v[1]; tx_bit = v[0];
    end else begin
      tx_en = 0; tx_bit = ~tx_bit;
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (aligned) begin
      ph = (ph + 1) % DIV;
      check(bit_clk == (ph < DIV/2), "R1 bit_clk shape", bit_clk, ph < DIV/2);
      if (ph == 0) model_tick();
      else check(sym_stb == 0, "R4 no strobe between ticks", sym_stb, 0);
      check(burst_active == m_active, "R6 R7 burst_active", burst_active, m_active);
      check(odd_err == m_odd, "R5 odd_err", odd_err, m_odd);
    end
  endtask

  task automatic do_reset();
    int n = 0;
    #7 rst_n = 0;
    #1;
    check(bit_clk == 0, "R9 bit_clk in reset", bit_clk, 0);
    check(sym_stb == 0, "R9 sym_stb in reset", sym_stb, 0);
    check(burst_active == 0, "R9 burst_active in reset", burst_active, 0);
    check(odd_err == 0, "R9 odd_err in reset", odd_err, 0);
    check(sym_i == 0 && sym_q == 0, "R9 rails in reset", {sym_i, sym_q}, 0);
    aligned = 0;
    stim_q.delete();
    tx_en = 0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1;
    do begin @(negedge clk); n++; end while (!bit_clk && n < 10);
    check(n == 3, "R9 first bit_clk rise after release", n, 3);
    ph = 0; aligned = 1;
    model_tick();
  endtask

  task automatic push_bits(input logic [31:0] pat, input int n);
    for (int k = n - 1; k >= 0; k--) stim_q.push_back({1'b1, pat[k]});
  endtask

  task automatic push_idle(input int n);
    for (int k = 0; k < n; k++) stim_q.push_back({1'b0, k[0]});
  endtask

  task automatic flush(input int extra_ticks);
    while (stim_q.size() > 0) step();
    repeat (extra_ticks * DIV) step();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    model_clear();
    do_reset();
    // R2 R3: all four bit pairs
    push_bits(32'b00_01_10_11, 8);
    flush(DRAIN + 3);
    // R8: toggling data with enable low
    push_idle(6);
    flush(1);
    // R7: second burst starts inside the drain window
    push_bits(32'hA5C, 12);
    push_idle(5);
    push_bits(32'b1001, 4);
    flush(DRAIN + 3);
    // R5: odd burst, pad and sticky flag
    push_bits(32'b10110, 5);
    flush(DRAIN + 3);
    // R2: next burst starts with I again
    push_bits(32'b110001, 6);
    flush(DRAIN + 3);
    // R9: asynchronous reset in the middle of a burst
    push_bits(32'hF0, 8);
    repeat (4 * DIV + 30) step();
    do_reset();
    push_bits(32'b0110, 4);
    flush(DRAIN + 3);
    finish_run();
  end

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog all requirements actual=timeout expected=completion");
      finish_run();
    end
  end
endmodule